// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

A bank of independent down-counters behind a simple register read/write bus. Each channel has a control word, an interval and a read-only current count. One shared enable mask and one shared pending mask cover all channels. A single interrupt line reports any pending channel whose interrupt is enabled. Counting is paced by slow tick-enable pulses on `tick_i`. Each channel picks one of these lines and divides it by a power of two before the count steps.

A channel runs either periodically, reloading itself from its interval, or once, stopping at its first expiry. Changes to the enable bit pass through a two-stage synchroniser that only advances on the channel's selected tick. Software must therefore allow two source ticks of further counting after it clears the enable bit. A channel loaded with all ones and left periodic serves as a free-running decreasing timebase.

Top module: `dntimer_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0. The enable mask is at byte offset 0x00 and the pending mask at 0x04, with bit n belonging to channel n. Channel n places its control word at 0x10+0x10·n, its interval at 0x14+0x10·n and its count at 0x18+0x10·n. Reads of unmapped offsets return 0.
- R2: The control word uses bit 0 for enable, bit 1 for reload, bits 3:2 for source, bits 6:4 for the prescale code and bit 7 for one-shot (0 = periodic). A control write with bit 1 set copies the interval into the count at that clock edge. Bit 1 always reads back 0, and the other fields read back as written.
- R3: The count register ignores writes. Writing the interval does not change the count until the next reload.
- R4: Counting begins only from the third selected source tick after the enable bit is set. After enable is cleared, the count still steps on exactly the next two selected source ticks and then holds.
- R5: With prescale code k, the count steps only on selected ticks whose number since the last reload is a multiple of 2^k.
- R6: The source field s selects `tick_i[s]`. Pulses on the other tick lines have no effect on the channel.
- R7: A step taken while the count is 0 is an expiry. It sets the channel's pending bit. A periodic channel then reloads the interval, so it expires every interval+1 steps.
- R8: On expiry a one-shot channel clears its enable bit and keeps its count at 0. It then expires no more until it is started again.
- R9: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If an expiry and a clear of the same bit fall in one cycle, the bit stays set.
- R10: `irq_o` is 1 exactly when some channel has both its pending bit and its enable-mask bit set. It follows the registers with no extra delay.
- R11: A count never wraps from 0 to all ones by stepping.
- R12: Channels are independent. Ticks, writes and expiries of one channel leave the other channels' counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | NSRC (4) | Tick-enable pulses, one clock wide, one line per source |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (8) | Byte offset |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, valid in the same cycle as a read request |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that each bus access lasts one cycle and that tick pulses are one clock wide. They also assume that a bus write never lands in the same cycle as a tick on the line the written channel selects. The stimulus keeps to this by driving ticks and bus accesses in separate negative-edge slots. The randomised part draws interval, prescale code, mode, channel and mask bit. It always lets at least three selected ticks pass after a disable, so each run starts from a cleared synchroniser. That is what the expected expiry tick, computed in the bench, depends on.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;
  localparam int unsigned OFF_IE    = 32'h00;
  localparam int unsigned OFF_STS   = 32'h04;
  localparam int unsigned OFF_CTL   = 32'h0;
  localparam int unsigned OFF_INTV  = 32'h4;
  localparam int unsigned OFF_CNT   = 32'h8;

  localparam int CB_EN     = 0;
  localparam int CB_LD     = 1;
  localparam int CB_SRC_LO = 2;
  localparam int CB_PRE_LO = 4;
  localparam int CB_OS     = 7;

  typedef struct packed {
    logic       os;
    logic [2:0] pre;
    logic [1:0] src;
    logic       en;
  } ctl_t;

  function automatic logic [7:0] ctl_pack(ctl_t c);
    return {c.os, c.pre, c.src, 1'b0, c.en};
  endfunction
endpackage

// File: rtl/dntimer_presc.sv
module dntimer_presc #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              ptick_o
);
  localparam int PW = (1 << CODE_W) - 1;

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] mask;

  always_comb mask = ~({PW{1'b1}} << code_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pcnt_q <= '0;
    else if (clr_i)  pcnt_q <= '0;
    else if (tick_i) pcnt_q <= pcnt_q + 1'b1;
  end

  // pulse on every 2^k-th tick counted from the last clear
  assign ptick_o = tick_i & ((pcnt_q & mask) == mask);
endmodule

// File: rtl/dntimer_sync.sv
module dntimer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (clr_i)  sr_q <= '0;
    else if (adv_i)  sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/dntimer_chan.sv
module dntimer_chan
  import dntimer_pkg::*;
#(
  parameter int CW     = 32,
  parameter int NSRC   = 4,
  parameter int DW     = 32,
  parameter int SYNC_N = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] tick_i,
  input  logic            ctl_we_i,
  input  logic            intv_we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   ctl_o,
  output logic [CW-1:0]   intv_o,
  output logic [CW-1:0]   cnt_o,
  output logic            expire_o,
  output logic            en_o,
  output logic            os_o,
  output logic            stick_o,
  output logic            load_o
);
  ctl_t          ctl_q;
  logic [CW-1:0] intv_q, cnt_q;
  logic [3:0]    tick_pad;
  logic          stick, ptick, run, step, load, expire, os_stop;

  always_comb begin
    tick_pad = '0;
    tick_pad[NSRC-1:0] = tick_i;
  end

  assign stick   = tick_pad[ctl_q.src];
  assign load    = ctl_we_i & wdata_i[CB_LD];
  assign step    = run & ptick;
  assign expire  = step & (cnt_q == '0);
  assign os_stop = expire & ctl_q.os;

  dntimer_presc #(.CODE_W(3)) presc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (stick),
    .clr_i  (load),
    .code_i (ctl_q.pre),
    .ptick_o(ptick)
  );

  // enable crosses into the tick domain; one-shot expiry stops at once
  dntimer_sync #(.STAGES(SYNC_N)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (stick),
    .clr_i (os_stop),
    .d_i   (ctl_q.en),
    .q_o   (run)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (ctl_we_i) begin
      ctl_q.en  <= wdata_i[CB_EN];
      ctl_q.src <= wdata_i[CB_SRC_LO +: 2];
      ctl_q.pre <= wdata_i[CB_PRE_LO +: 3];
      ctl_q.os  <= wdata_i[CB_OS];
    end else if (os_stop) begin
      ctl_q.en  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        intv_q <= '0;
    else if (intv_we_i) intv_q <= wdata_i[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (load) cnt_q <= intv_q;
    else if (step) begin
      if (cnt_q == '0) cnt_q <= ctl_q.os ? '0 : intv_q;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ctl_o    = DW'(ctl_pack(ctl_q));
  assign intv_o   = intv_q;
  assign cnt_o    = cnt_q;
  assign expire_o = expire;
  assign en_o     = ctl_q.en;
  assign os_o     = ctl_q.os;
  assign stick_o  = stick;
  assign load_o   = load;
endmodule

// File: rtl/dntimer_bank.sv
module dntimer_bank
  import dntimer_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CW     = 32,
  parameter int NSRC   = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int SYNC_N = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] tick_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o
);
  localparam int IDX_W = AW - 4;

  logic [NCH-1:0] ie_q, sts_q, sts_clr;
  logic [NCH-1:0] expire_w, en_w, os_w, stick_w, load_w, ctl_we, intv_we;
  logic [CW-1:0]  cnt_w  [NCH];
  logic [CW-1:0]  intv_w [NCH];
  logic [DW-1:0]  ctl_w  [NCH];
  logic           wr;
  logic [IDX_W-1:0] grp;
  logic [3:0]     off;

  assign wr  = req_i & we_i;
  assign grp = addr_i[AW-1:4];
  assign off = addr_i[3:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ctl_we[g]  = wr && (grp == IDX_W'(g + 1)) && (off == 4'(OFF_CTL));
    assign intv_we[g] = wr && (grp == IDX_W'(g + 1)) && (off == 4'(OFF_INTV));

    dntimer_chan #(.CW(CW), .NSRC(NSRC), .DW(DW), .SYNC_N(SYNC_N)) chan_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .ctl_we_i (ctl_we[g]),
      .intv_we_i(intv_we[g]),
      .wdata_i  (wdata_i),
      .ctl_o    (ctl_w[g]),
      .intv_o   (intv_w[g]),
      .cnt_o    (cnt_w[g]),
      .expire_o (expire_w[g]),
      .en_o     (en_w[g]),
      .os_o     (os_w[g]),
      .stick_o  (stick_w[g]),
      .load_o   (load_w[g])
    );
  end

  assign sts_clr = (wr && addr_i == AW'(OFF_STS)) ? wdata_i[NCH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= '0;
      sts_q <= '0;
    end else begin
      if (wr && addr_i == AW'(OFF_IE)) ie_q <= wdata_i[NCH-1:0];
      sts_q <= (sts_q & ~sts_clr) | expire_w;  // set beats clear
    end
  end

  assign irq_o = |(sts_q & ie_q);

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (addr_i == AW'(OFF_IE))       rdata_o = DW'(ie_q);
      else if (addr_i == AW'(OFF_STS)) rdata_o = DW'(sts_q);
      else begin
        for (int i = 0; i < NCH; i++) begin
          if (grp == IDX_W'(i + 1)) begin
            case (off)
              4'(OFF_CTL):  rdata_o = ctl_w[i];
              4'(OFF_INTV): rdata_o = DW'(intv_w[i]);
              4'(OFF_CNT):  rdata_o = DW'(cnt_w[i]);
              default:      rdata_o = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/dntimer_chk.sv
module dntimer_chk #(
  parameter int NCH = 2,
  parameter int CW  = 32,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           we_i,
  input logic [AW-1:0]  addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic           irq_o,
  input logic [NCH-1:0] ie_q,
  input logic [NCH-1:0] sts_q,
  input logic [NCH-1:0] expire_w,
  input logic [NCH-1:0] en_w,
  input logic [NCH-1:0] os_w,
  input logic [NCH-1:0] stick_w,
  input logic [NCH-1:0] load_w,
  input logic [CW-1:0]  cnt_w  [NCH],
  input logic [CW-1:0]  intv_w [NCH]
);
  logic ie_wr, sts_wr;
  assign ie_wr  = req_i && we_i && addr_i == AW'(0);
  assign sts_wr = req_i && we_i && addr_i == AW'(4);

  p_irq_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|expire_w) || $past(ie_wr)));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic ctl_wr;
    assign ctl_wr = req_i && we_i && addr_i == AW'(16 * (g + 1));

    p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_w[g] |=> cnt_w[g] == $past(intv_w[g]));

    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stick_w[g] && !load_w[g]) |=> $stable(cnt_w[g]));

    p_no_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_w[g] == '0 && !load_w[g] && intv_w[g] != '1) |=> cnt_w[g] != '1);

    p_os_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (expire_w[g] && os_w[g] && !ctl_wr) |=> !en_w[g]);

    p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_w[g] |=> sts_q[g]);

    p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sts_wr && wdata_i[g] && !expire_w[g]) |=> !sts_q[g]);
  end
endmodule

bind dntimer_bank dntimer_chk #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .ie_q    (ie_q),
  .sts_q   (sts_q),
  .expire_w(expire_w),
  .en_w    (en_w),
  .os_w    (os_w),
  .stick_w (stick_w),
  .load_w  (load_w),
  .cnt_w   (cnt_w),
  .intv_w  (intv_w)
);

// File: tb/dntimer_bank_tb_top.sv
`timescale 1ns/1ps
module dntimer_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  tick_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  dntimer_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] a_ctl(int ch);  return 8'(16 + 16 * ch); endfunction
  function automatic logic [7:0] a_intv(int ch); return 8'(20 + 16 * ch); endfunction
  function automatic logic [7:0] a_cnt(int ch);  return 8'(24 + 16 * ch); endfunction

  // selected tick number at which the first expiry occurs after a reload
  function automatic int exp_tick(int n, int k);
    int c = n;
    for (int t = 1; t < 100000; t++) begin
      if (t >= 3 && (t % (1 << k)) == 0) begin
        if (c == 0) return t;
        c--;
      end
    end
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    req_i = 0;
  endtask

  task automatic tick(input int line);
    @(negedge clk_i);
    tick_i[line] = 1'b1;
    @(negedge clk_i);
    tick_i = '0;
  endtask

  task automatic ticks(input int line, input int n);
    for (int i = 0; i < n; i++) tick(line);
  endtask

  initial begin
    logic [31:0] d, c0;
    int seed_v;
    seed_v = int'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    rd(8'h00, d); chk("R1 ie reset", d, 0);
    rd(8'h04, d); chk("R1 sts reset", d, 0);
    rd(a_ctl(0), d); chk("R1 ctl0 reset", d, 0);
    rd(a_cnt(1), d); chk("R1 cnt1 reset", d, 0);
    rd(8'h0C, d); chk("R1 unmapped", d, 0);
    #1 chk("R1 irq reset", {31'b0, irq_o}, 0);

    // R3 interval write and count write do not touch count
    wr(a_intv(0), 5);
    rd(a_cnt(0), d); chk("R3 intv no load", d, 0);
    wr(a_cnt(0), 123);
    rd(a_cnt(0), d); chk("R3 cnt read-only", d, 0);

    // R2 reload, self-clearing bit
    wr(a_ctl(0), 32'h03);
    rd(a_ctl(0), d); chk("R2 reload reads 0", d, 32'h01);
    rd(a_cnt(0), d); chk("R2 loaded", d, 5);

    // R4 start latency
    ticks(0, 2);
    rd(a_cnt(0), d); chk("R4 held two ticks", d, 5);
    tick(0);
    rd(a_cnt(0), d); chk("R4 third tick steps", d, 4);
    tick(0);
    // R4 disable latency
    wr(a_ctl(0), 32'h00);
    tick(0); tick(0);
    rd(a_cnt(0), d); chk("R4 two ticks after disable", d, 1);
    tick(0);
    rd(a_cnt(0), d); chk("R4 stopped", d, 1);

    // R8 one-shot expiry, R10 irq
    wr(8'h00, 1);
    wr(a_intv(0), 2);
    wr(a_ctl(0), 32'h83);
    ticks(0, 4);
    rd(8'h04, d); chk("R7 no early expiry", d, 0);
    tick(0);
    rd(8'h04, d); chk("R7 one-shot pending", d, 1);
    #1 chk("R10 irq set", {31'b0, irq_o}, 1);
    rd(a_ctl(0), d); chk("R8 enable cleared", d, 32'h80);
    // R9 write-one-to-clear
    wr(8'h04, 0);
    rd(8'h04, d); chk("R9 write 0 keeps", d, 1);
    wr(8'h04, 1);
    rd(8'h04, d); chk("R9 write 1 clears", d, 0);
    #1 chk("R10 irq clear", {31'b0, irq_o}, 0);
    ticks(0, 4);
    rd(8'h04, d); chk("R8 no re-expiry", d, 0);
    rd(a_cnt(0), d); chk("R11 stays zero", d, 0);

    // R7 periodic
    wr(a_ctl(0), 32'h03);
    ticks(0, 5);
    rd(8'h04, d); chk("R7 periodic pending", d, 1);
    rd(a_cnt(0), d); chk("R7 reloaded", d, 2);
    wr(8'h04, 1);
    ticks(0, 2);
    rd(8'h04, d); chk("R7 not yet", d, 0);
    tick(0);
    rd(8'h04, d); chk("R7 second expiry", d, 1);
    wr(a_ctl(0), 0); ticks(0, 3); wr(8'h04, 3);

    // R5 prescale code 2
    wr(a_intv(0), 1);
    wr(a_ctl(0), 32'h23);
    ticks(0, 4);
    rd(a_cnt(0), d); chk("R5 step at tick 4", d, 0);
    ticks(0, 3);
    rd(8'h04, d); chk("R5 no expiry at 7", d, 0);
    tick(0);
    rd(8'h04, d); chk("R5 expiry at 8", d, 1);
    wr(a_ctl(0), 0); ticks(0, 3); wr(8'h04, 3);

    // R6 source select, R12 independence
    rd(a_cnt(0), c0);
    wr(a_intv(1), 3);
    wr(a_ctl(1), 32'h07);
    rd(a_ctl(1), d); chk("R2 src readback", d, 32'h05);
    ticks(0, 5);
    rd(a_cnt(1), d); chk("R6 other line ignored", d, 3);
    ticks(1, 3);
    rd(a_cnt(1), d); chk("R6 own line steps", d, 2);
    rd(a_cnt(0), d); chk("R12 ch0 untouched", d, c0);
    wr(a_ctl(1), 32'h04); ticks(1, 3); wr(8'h04, 3);
    wr(a_ctl(1), 32'h00);

    // random runs on line 0
    for (int it = 0; it < 10; it++) begin
      int ch, n, k, os, ieb, et;
      bit early;
      ch = $urandom % 2; n = $urandom % 12; k = $urandom % 3;
      os = $urandom % 2; ieb = $urandom % 2;
      wr(8'h00, 32'(ieb << ch));
      wr(a_intv(ch), 32'(n));
      wr(8'h04, 3);
      wr(a_ctl(ch), {24'b0, 1'(os), 3'(k), 2'b00, 2'b11});
      et = exp_tick(n, k);
      early = 0;
      for (int t = 1; t < et; t++) begin
        tick(0);
        rd(8'h04, d);
        if (d != 0) early = 1;
      end
      chk("R5 random no early expiry", {31'b0, early}, 0);
      tick(0);
      rd(8'h04, d); chk("R7 random expiry", d, 32'(1 << ch));
      #1 chk("R10 random irq", {31'b0, irq_o}, 32'(ieb));
      rd(a_cnt(ch), d); chk("R8 random count after expiry", d, os ? 0 : 32'(n));
      rd(a_ctl(ch), d); chk("R8 random enable", d[0], os ? 0 : 1);
      wr(a_ctl(ch), 0); ticks(0, 3); wr(8'h04, 3); wr(8'h00, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule